// File: doc/BRIEF.md
# FM Low-Frequency Oscillator Step Unit

This block is the slow modulation source for one FM voice. A 32-bit count, split into an 8-bit integer part and 24 fractional bits, advances by a programmable increment on every sample tick. From the integer part it derives two registered outputs. The first is an amplitude-modulation depth folded into a triangle. The second is a phase-modulation step index that moves at a quarter of the depth's rate. Both outputs change only when the relevant part of the integer count changes, so a small increment holds them steady across many ticks.

The block also applies the depth to each operator's envelope attenuation. Each operator has its own enable bit, and a 2-bit sensitivity scales the depth down before it is added. Turning the turning oscillator off clears the count and zeroes both outputs. The envelope path then passes through unchanged. The lookup from step index to pitch offset sits in a neighbouring block.

Top module: `fm_lfo_step`

## Requirements
- R1: After reset, am_o and pm_o are 0, the count is 0, and every env_o slice equals its env_i slice.
- R2: With lfo_en_i high, each cycle with tick_i high adds inc_i to the 32-bit count modulo 2^32. The integer part is count bits [31:24].
- R3: While lfo_en_i is high, a cycle without tick_i leaves am_o and pm_o unchanged. A tick whose sum leaves the integer part unchanged also leaves them unchanged.
- R4: When a tick changes the integer part to value n, am_o becomes {t, 1'b0} on the next clock edge. Here t = n[5:0] when n[6] is 1, and t = ~n[5:0] when n[6] is 0.
- R5: pm_o becomes n[6:2] on the next clock edge only when a tick changes n[7:2]. Otherwise pm_o holds its value.
- R6: A cycle with lfo_en_i low clears the count to 0 and forces am_o and pm_o to 0 from the next edge.
- R7: For operator k, when lfo_en_i is high and am_mask_i[k] is 1, env_o slice k = env_i slice k + (am_o >> s). The shift s is 8, 3, 1 or 0 for am_sens_i values 0, 1, 2 and 3. The output is ENV_W+1 bits wide, with no clipping.
- R8: For operator k, when lfo_en_i is low or am_mask_i[k] is 0, env_o slice k equals env_i slice k. The other operators are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lfo_en_i | input | 1 | Oscillator enable |
| tick_i | input | 1 | Sample tick, advances the count |
| inc_i | input | 32 | Count increment, 8.24 fixed point |
| am_sens_i | input | 2 | Depth sensitivity select |
| am_mask_i | input | NUM_OP | Per-operator depth enable |
| env_i | input | NUM_OP*ENV_W | Envelope attenuation, operator 0 in the low bits |
| am_o | output | 7 | Triangle depth, always even |
| pm_o | output | 5 | Phase-modulation step index |
| env_o | output | NUM_OP*(ENV_W+1) | Envelope attenuation with depth added |

## Verification
The bench builds the block with its defaults: four operators, a 10-bit envelope and an 8.24 count. With those widths, whole-step and half-step increments walk the triangle through both of its folds. Wide random increments wrap the count past 2^32. Envelope values near 1023 push the sum into the extra output bit. Random masks and sensitivities cover every shift value and every mix of gated operators. Random enable drops check that the count restarts from zero.

// File: rtl/fm_lfo_pkg.sv
package fm_lfo_pkg;
  localparam int AM_W = 7;
  localparam int PM_W = 5;

  // triangle from 7 count bits, stored doubled
  function automatic logic [AM_W-1:0] am_fold(input logic [6:0] c);
    logic [5:0] t;
    t = c[6] ? c[5:0] : ~c[5:0];
    return {t, 1'b0};
  endfunction

  function automatic logic [3:0] am_shift(input logic [1:0] s);
    case (s)
      2'd0:    return 4'd8;
      2'd1:    return 4'd3;
      2'd2:    return 4'd1;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/fm_lfo_accum.sv
module fm_lfo_accum #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             step_o
);
  logic [CNT_W-1:0] cnt_q;

  assign step_o    = en_i & tick_i;
  assign cnt_nxt_o = cnt_q + inc_i;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (step_o) cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/fm_lfo_shape.sv
module fm_lfo_shape
  import fm_lfo_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic [AM_W-1:0]  am_o,
  output logic [PM_W-1:0]  pm_o
);
  localparam int INT_W = CNT_W - FRAC_W;

  logic [INT_W-1:0] int_cur, int_nxt;
  logic             int_chg, qtr_chg;
  logic [AM_W-1:0]  am_q;
  logic [PM_W-1:0]  pm_q;

  assign int_cur = cnt_i[CNT_W-1:FRAC_W];
  assign int_nxt = cnt_nxt_i[CNT_W-1:FRAC_W];
  assign int_chg = step_i && (int_nxt != int_cur);
  assign qtr_chg = step_i && (int_nxt[INT_W-1:2] != int_cur[INT_W-1:2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      am_q <= '0;
      pm_q <= '0;
    end else if (!en_i) begin
      am_q <= '0;
      pm_q <= '0;
    end else begin
      if (int_chg) am_q <= am_fold(int_nxt[6:0]);
      if (qtr_chg) pm_q <= int_nxt[6:2];
    end
  end

  assign am_o = am_q;
  assign pm_o = pm_q;
endmodule

// File: rtl/fm_lfo_am_apply.sv
module fm_lfo_am_apply
  import fm_lfo_pkg::*;
#(
  parameter int ENV_W = 10
) (
  input  logic             en_i,
  input  logic             mask_i,
  input  logic [1:0]       sens_i,
  input  logic [AM_W-1:0]  am_i,
  input  logic [ENV_W-1:0] env_i,
  output logic [ENV_W:0]   env_o
);
  logic [AM_W-1:0] am_sc;

  always_comb begin
    am_sc = (en_i && mask_i) ? (am_i >> am_shift(sens_i)) : '0;
    env_o = {1'b0, env_i} + {{(ENV_W+1-AM_W){1'b0}}, am_sc};
  end
endmodule

// File: rtl/fm_lfo_step.sv
module fm_lfo_step
  import fm_lfo_pkg::*;
#(
  parameter int NUM_OP = 4,
  parameter int ENV_W  = 10,
  parameter int CNT_W  = 32,
  parameter int FRAC_W = 24
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      lfo_en_i,
  input  logic                      tick_i,
  input  logic [CNT_W-1:0]          inc_i,
  input  logic [1:0]                am_sens_i,
  input  logic [NUM_OP-1:0]         am_mask_i,
  input  logic [NUM_OP*ENV_W-1:0]   env_i,
  output logic [AM_W-1:0]           am_o,
  output logic [PM_W-1:0]           pm_o,
  output logic [NUM_OP*(ENV_W+1)-1:0] env_o
);
  localparam int OUT_W = ENV_W + 1;

  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             step;

  fm_lfo_accum #(.CNT_W(CNT_W)) u_accum (
    .clk_i, .rst_ni, .en_i(lfo_en_i), .tick_i, .inc_i,
    .cnt_o(cnt), .cnt_nxt_o(cnt_nxt), .step_o(step)
  );

  fm_lfo_shape #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_shape (
    .clk_i, .rst_ni, .en_i(lfo_en_i), .step_i(step),
    .cnt_i(cnt), .cnt_nxt_i(cnt_nxt), .am_o, .pm_o
  );

  for (genvar k = 0; k < NUM_OP; k++) begin : g_op
    fm_lfo_am_apply #(.ENV_W(ENV_W)) u_apply (
      .en_i(lfo_en_i), .mask_i(am_mask_i[k]), .sens_i(am_sens_i), .am_i(am_o),
      .env_i(env_i[k*ENV_W +: ENV_W]), .env_o(env_o[k*OUT_W +: OUT_W])
    );
  end
endmodule

// File: rtl/fm_lfo_step_chk.sv
module fm_lfo_step_chk #(
  parameter int NUM_OP = 4,
  parameter int ENV_W  = 10
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        lfo_en_i,
  input logic                        tick_i,
  input logic [NUM_OP-1:0]           am_mask_i,
  input logic [NUM_OP*ENV_W-1:0]     env_i,
  input logic [6:0]                  am_o,
  input logic [4:0]                  pm_o,
  input logic [NUM_OP*(ENV_W+1)-1:0] env_o
);
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfo_en_i && !tick_i |=> $stable(am_o) && $stable(pm_o));

  p_off_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lfo_en_i |=> am_o == 7'd0 && pm_o == 5'd0);

  for (genvar k = 0; k < NUM_OP; k++) begin : g_op
    p_gate_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lfo_en_i || !am_mask_i[k]) |->
        env_o[k*(ENV_W+1) +: ENV_W+1] == {1'b0, env_i[k*ENV_W +: ENV_W]});
    p_add_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      env_o[k*(ENV_W+1) +: ENV_W+1] >= {1'b0, env_i[k*ENV_W +: ENV_W]} &&
      env_o[k*(ENV_W+1) +: ENV_W+1] <= {1'b0, env_i[k*ENV_W +: ENV_W]} + am_o);
  end
endmodule

bind fm_lfo_step fm_lfo_step_chk #(.NUM_OP(NUM_OP), .ENV_W(ENV_W)) u_chk (.*);

// File: tb/sim_fm_lfo_step.sv
module sim_fm_lfo_step;
  localparam int NOP = 4;
  localparam int EW  = 10;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   lfo_en_i = 1'b0;
  logic                   tick_i = 1'b0;
  logic [31:0]            inc_i = '0;
  logic [1:0]             am_sens_i = '0;
  logic [NOP-1:0]         am_mask_i = '0;
  logic [NOP*EW-1:0]      env_i = '0;
  logic [6:0]             am_o;
  logic [4:0]             pm_o;
  logic [NOP*(EW+1)-1:0]  env_o;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_cnt;
  logic [6:0]  m_am;
  logic [4:0]  m_pm;
  logic        last_en;
  logic        last_chg;

  always #10 clk_i = ~clk_i;

  fm_lfo_step u0 (.*);

  function automatic logic [6:0] tri_of(input logic [7:0] n);
    logic [5:0] t;
    t = n[6] ? n[5:0] : (6'h3F ^ n[5:0]);
    return {t, 1'b0};
  endfunction

  function automatic int sh_of(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 3 : (s == 2'd2) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_env();
    for (int k = 0; k < NOP; k++) begin
      int e, a;
      e = int'(env_i[k*EW +: EW]);
      a = int'(env_o[k*(EW+1) +: EW+1]);
      if (lfo_en_i && am_mask_i[k]) chk("R7 env add", a, e + (int'(m_am) >> sh_of(am_sens_i)));
      else                          chk("R8 env pass", a, e);
    end
  endtask

  task automatic model_step();
    logic [31:0] nx;
    last_chg = 1'b0;
    if (!lfo_en_i) begin
      m_cnt = '0; m_am = '0; m_pm = '0;
    end else if (tick_i) begin
      nx = m_cnt + inc_i;
      if (nx[31:24] != m_cnt[31:24]) begin m_am = tri_of(nx[31:24]); last_chg = 1'b1; end
      if (nx[31:26] != m_cnt[31:26]) m_pm = nx[30:26];
      m_cnt = nx;
    end
    last_en = lfo_en_i;
  endtask

  // drive one cycle: check state, apply inputs, check comb path, predict
  task automatic cyc(input logic en, input logic tk, input logic [31:0] inc,
                     input logic [1:0] s, input logic [NOP-1:0] m, input logic [NOP*EW-1:0] e);
    string tag;
    @(negedge clk_i);
    tag = !last_en ? "R6" : (last_chg ? "R4" : "R3");
    chk({tag, " am"}, int'(am_o), int'(m_am));
    chk(!last_en ? "R6 pm" : "R5 pm", int'(pm_o), int'(m_pm));
    lfo_en_i = en; tick_i = tk; inc_i = inc; am_sens_i = s; am_mask_i = m; env_i = e;
    #1;
    chk_env();
    model_step();
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [NOP*EW-1:0] ev;
    void'($urandom(32'd2024));
    m_cnt = '0; m_am = '0; m_pm = '0; last_en = 1'b0; last_chg = 1'b0;
    env_i = {10'd3, 10'd1023, 10'd500, 10'd7};
    #1;
    chk("R1 am reset", int'(am_o), 0);
    chk("R1 pm reset", int'(pm_o), 0);
    chk_env();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R2: whole steps walk the integer part, covering both folds
    for (int i = 0; i < 140; i++) cyc(1'b1, 1'b1, 32'h0100_0000, 2'd3, 4'hF, env_i);
    // R2: half steps change the integer part on every second tick
    cyc(1'b0, 1'b0, 0, 2'd3, 4'hF, env_i);
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 32'h0080_0000, 2'd3, 4'hF, env_i);
    // R2: wrap at 2^32
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 32'hC000_0000, 2'd2, 4'b0101, env_i);
    // R3: no ticks
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 32'h0100_0000, 2'd1, 4'hF, env_i);
    // R6: disable then resume
    cyc(1'b0, 1'b1, 32'h0300_0000, 2'd3, 4'hF, env_i);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 32'h0300_0000, 2'd3, 4'hF, {NOP{10'h3FF}});

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] inc;
      int r;
      r = $urandom_range(0, 3);
      inc = (r == 0) ? $urandom_range(0, 32'h00FF_FFFF) :
            (r == 1) ? $urandom_range(0, 32'h0400_0000) :
            (r == 2) ? 32'h0100_0000 : $urandom;
      for (int k = 0; k < NOP; k++) ev[k*EW +: EW] = EW'($urandom);
      cyc(($urandom_range(0, 19) != 0), 1'($urandom), inc, 2'($urandom),
          NOP'($urandom), ev);
    end
    cyc(1'b1, 1'b0, 0, 2'd0, '0, '0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule